// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is the storage and output end of one logic cell in a small programmable fabric. It takes the XOR result and a few product terms from the cell's logic array and holds a single bit of state. Static configuration inputs choose how the bit behaves: an edge-triggered D, T, JK or SR register, or a latch that is transparent while its clock is high. The same inputs choose where the data, clock, clock enable, asynchronous reset and asynchronous preset come from.

The stage drives the value and the enable of the cell's pin driver. The pin value is either the stored bit or the combinational XOR result. A buried feedback bit goes back to the fabric's routing. The configuration inputs are meant to be held steady while the fabric runs. They change only while the selected clock is low.

A chip-level active-low reset clears the stored bit. Its release is synchronised to the global clock.

Top module: `mcell_reg_stage`

## Requirements
- R1: While `rst_n` is low, and for two global clock edges after it rises, the stored bit is 0. With a registered output, `pin_data` and `fb_out` both read 0.
- R2: `cfg_mode` codes are 0=D, 1=T, 2=JK, 3=SR and 4=latch. Codes 5 to 7 act as D. In D mode the selected data bit is stored on the rising clock edge. The data bit is `xor_in` when `cfg_dsel`=0 and `pt_data` when `cfg_dsel`=1.
- R3: In T mode a data bit of 1 inverts the stored bit on a rising edge, and a 0 keeps it.
- R4: In JK mode J is the selected data bit and K is `pt_k`. On a rising edge: J=K=0 holds, J=1 K=0 sets, J=0 K=1 clears, and J=K=1 inverts.
- R5: In SR mode S is the selected data bit and R is `pt_k`. On a rising edge: S=R=0 holds, S=1 R=0 sets, and S=0 R=1 clears. S=R=1 also clears.
- R6: In latch mode the stored output follows the selected data bit while the selected clock is high. It keeps the value present at the falling edge while the clock is low.
- R7: `cfg_ptclk`=0 clocks the cell from `glb_clk`. `cfg_ptclk`=1 clocks it from `pt_clk`, and then `glb_clk` edges have no effect.
- R8: With `glb_clk` selected and `cfg_ce_en`=1, a rising edge is ignored while `pt_ce` is low. With `pt_clk` selected, `pt_ce` has no effect.
- R9: `cfg_ar_sel` picks the asynchronous reset: 0=none, 1=`glb_clr_n` low, 2=`pt_ar` high, 3=either of those. An active reset clears the bit at once, without a clock.
- R10: With `cfg_ap_en`=1, `pt_ap` high sets the bit at once. When reset and preset are both active, reset wins.
- R11: With `cfg_comb`=0, `pin_data` and `fb_out` carry the stored bit. With `cfg_comb`=1, `pin_data` carries `xor_in`. `fb_out` then carries the stored bit only when `cfg_dsel`=1 and `cfg_fb_reg`=1; otherwise it carries `xor_in`.
- R12: `cfg_oe_sel` picks `pin_oe`: 0=always 1, 1=always 0, 2=`oe_n[0]` inverted, 3=`oe_n[1]` inverted, 4=`pt_oe`. Codes 5 to 7 give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Chip reset, active low |
| glb_clk | input | 1 | Global clock |
| glb_clr_n | input | 1 | Global clear, active low |
| oe_n | input | 2 | Global output-enable pins, active low |
| cfg_mode | input | 3 | Storage mode code |
| cfg_dsel | input | 1 | Data source: 0 XOR result, 1 separate term |
| cfg_ptclk | input | 1 | Clock source: 0 global, 1 product term |
| cfg_ce_en | input | 1 | Use `pt_ce` as clock enable |
| cfg_ar_sel | input | 2 | Asynchronous reset source |
| cfg_ap_en | input | 1 | Enable product-term preset |
| cfg_comb | input | 1 | Pin carries combinational value |
| cfg_fb_reg | input | 1 | Feedback taken from register in combinational mode |
| cfg_oe_sel | input | 3 | Output-enable source |
| xor_in | input | 1 | XOR gate result |
| pt_data | input | 1 | Separate data product term |
| pt_k | input | 1 | K / R product term |
| pt_clk | input | 1 | Product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| pt_ar | input | 1 | Product-term reset |
| pt_ap | input | 1 | Product-term preset |
| pt_oe | input | 1 | Product-term output enable |
| pin_data | output | 1 | Value to pin driver |
| pin_oe | output | 1 | Enable to pin driver |
| fb_out | output | 1 | Buried feedback |

## Verification
Edge-mode results go through one register. They appear after the rising edge of the selected clock that samples them. The bench changes inputs 2 ns after a global edge and checks 2 ns after the next one. The latch path, the output-enable mux, the output and feedback selection, and the asynchronous reset and preset need no clock edge. Their checks run 1 ns after the stimulus, well clear of any edge. Product-term clock pulses and clock-source switches are placed while `glb_clk` is low. This keeps the selected clock free of stray edges.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [2:0] {
    MD_D     = 3'd0,
    MD_T     = 3'd1,
    MD_JK    = 3'd2,
    MD_SR    = 3'd3,
    MD_LATCH = 3'd4
  } store_mode_e;

  typedef enum logic [1:0] {
    AR_NONE  = 2'd0,
    AR_GCLR  = 2'd1,
    AR_TERM  = 2'd2,
    AR_BOTH  = 2'd3
  } ar_src_e;

  typedef enum logic [2:0] {
    OE_ON    = 3'd0,
    OE_OFF   = 3'd1,
    OE_PIN0  = 3'd2,
    OE_PIN1  = 3'd3,
    OE_TERM  = 3'd4
  } oe_src_e;
endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic       glb_clk,
  input  logic       pt_clk,
  input  logic       cfg_ptclk,
  input  logic       cfg_ce_en,
  input  logic       pt_ce,
  input  logic [1:0] cfg_ar_sel,
  input  logic       glb_clr_n,
  input  logic       pt_ar,
  input  logic       cfg_ap_en,
  input  logic       pt_ap,
  input  logic       rst_ok,
  output logic       eff_clk,
  output logic       ce_ok,
  output logic       clr,
  output logic       set
);
  logic ar_act;

  // The source is static configuration, so the clock mux does not glitch in use
  assign eff_clk = cfg_ptclk ? pt_clk : glb_clk;
  // The clock enable applies only to the global clock
  assign ce_ok   = cfg_ptclk | ~cfg_ce_en | pt_ce;

  always_comb begin
    unique case (ar_src_e'(cfg_ar_sel))
      AR_NONE: ar_act = 1'b0;
      AR_GCLR: ar_act = ~glb_clr_n;
      AR_TERM: ar_act = pt_ar;
      AR_BOTH: ar_act = ~glb_clr_n | pt_ar;
      default: ar_act = 1'b0;
    endcase
  end

  assign clr = ar_act | ~rst_ok;
  assign set = cfg_ap_en & pt_ap;
endmodule

// File: rtl/mcell_next.sv
module mcell_next
  import mcell_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       q,
  input  logic       a_in,
  input  logic       b_in,
  output logic       nxt
);
  always_comb begin
    unique case (store_mode_e'(mode))
      MD_T:  nxt = q ^ a_in;
      MD_JK: begin
        unique case ({a_in, b_in})
          2'b00:   nxt = q;
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = ~q;
        endcase
      end
      MD_SR: begin
        unique case ({a_in, b_in})
          2'b00:   nxt = q;
          2'b10:   nxt = 1'b1;
          default: nxt = 1'b0;
        endcase
      end
      default: nxt = a_in;
    endcase
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store (
  input  logic eff_clk,
  input  logic ce_ok,
  input  logic clr,
  input  logic set,
  input  logic rst_ok,
  input  logic is_latch,
  input  logic d_src,
  input  logic nxt,
  output logic edge_q,
  output logic q_out
);
  logic held_q;
  logic latch_view;

  // Edge register: the reset is tested before the preset, so it wins
  always_ff @(posedge eff_clk or posedge clr or posedge set) begin
    if (clr)        edge_q <= 1'b0;
    else if (set)   edge_q <= 1'b1;
    else if (ce_ok) edge_q <= nxt;
  end

  // Latch hold: keeps the data present as the clock falls
  always_ff @(negedge eff_clk or posedge clr or posedge set) begin
    if (clr)      held_q <= 1'b0;
    else if (set) held_q <= 1'b1;
    else          held_q <= d_src;
  end

  always_comb begin
    if (clr)          latch_view = 1'b0;
    else if (set)     latch_view = 1'b1;
    else if (eff_clk) latch_view = d_src;
    else              latch_view = held_q;
  end

  assign q_out = is_latch ? latch_view : edge_q;

  // R9
  ar_clears_chk: assert property (@(posedge eff_clk) disable iff (!rst_ok)
    clr |-> (q_out == 1'b0));

  // R10
  ap_sets_chk: assert property (@(posedge eff_clk) disable iff (!rst_ok)
    (set && !clr) |-> (q_out == 1'b1));

  // R8
  ce_hold_chk: assert property (@(posedge eff_clk) disable iff (!rst_ok || clr || set)
    (!ce_ok && !is_latch) |=> $stable(edge_q));
endmodule

// File: rtl/mcell_out.sv
module mcell_out
  import mcell_pkg::*;
#(
  parameter int N_OE = 2
) (
  input  logic            q_out,
  input  logic            xor_in,
  input  logic            cfg_comb,
  input  logic            cfg_dsel,
  input  logic            cfg_fb_reg,
  input  logic [2:0]      cfg_oe_sel,
  input  logic [N_OE-1:0] oe_n,
  input  logic            pt_oe,
  output logic            pin_data,
  output logic            fb_out,
  output logic            pin_oe
);
  localparam int PIN_BASE = int'(OE_PIN0);

  assign pin_data = cfg_comb ? xor_in : q_out;
  assign fb_out   = (!cfg_comb || (cfg_dsel && cfg_fb_reg)) ? q_out : xor_in;

  always_comb begin
    pin_oe = 1'b0;
    if (cfg_oe_sel == OE_ON)   pin_oe = 1'b1;
    if (cfg_oe_sel == OE_TERM) pin_oe = pt_oe;
    for (int i = 0; i < N_OE; i++) begin
      if (int'(cfg_oe_sel) == PIN_BASE + i) pin_oe = ~oe_n[i];
    end
  end
endmodule

// File: rtl/mcell_reg_stage.sv
module mcell_reg_stage
  import mcell_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_OE        = 2
) (
  input  logic            rst_n,
  input  logic            glb_clk,
  input  logic            glb_clr_n,
  input  logic [N_OE-1:0] oe_n,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_dsel,
  input  logic            cfg_ptclk,
  input  logic            cfg_ce_en,
  input  logic [1:0]      cfg_ar_sel,
  input  logic            cfg_ap_en,
  input  logic            cfg_comb,
  input  logic            cfg_fb_reg,
  input  logic [2:0]      cfg_oe_sel,
  input  logic            xor_in,
  input  logic            pt_data,
  input  logic            pt_k,
  input  logic            pt_clk,
  input  logic            pt_ce,
  input  logic            pt_ar,
  input  logic            pt_ap,
  input  logic            pt_oe,
  output logic            pin_data,
  output logic            pin_oe,
  output logic            fb_out
);
  logic rst_ok, eff_clk, ce_ok, clr, set;
  logic d_src, nxt, edge_q, q_out, is_latch;

  assign d_src    = cfg_dsel ? pt_data : xor_in;
  assign is_latch = (cfg_mode == MD_LATCH);

  mcell_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(glb_clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  mcell_ctrl u_ctrl (
    .glb_clk(glb_clk), .pt_clk(pt_clk), .cfg_ptclk(cfg_ptclk),
    .cfg_ce_en(cfg_ce_en), .pt_ce(pt_ce), .cfg_ar_sel(cfg_ar_sel),
    .glb_clr_n(glb_clr_n), .pt_ar(pt_ar), .cfg_ap_en(cfg_ap_en),
    .pt_ap(pt_ap), .rst_ok(rst_ok), .eff_clk(eff_clk), .ce_ok(ce_ok),
    .clr(clr), .set(set)
  );

  mcell_next u_next (
    .mode(cfg_mode), .q(edge_q), .a_in(d_src), .b_in(pt_k), .nxt(nxt)
  );

  mcell_store u_store (
    .eff_clk(eff_clk), .ce_ok(ce_ok), .clr(clr), .set(set), .rst_ok(rst_ok),
    .is_latch(is_latch), .d_src(d_src), .nxt(nxt), .edge_q(edge_q),
    .q_out(q_out)
  );

  mcell_out #(.N_OE(N_OE)) u_out (
    .q_out(q_out), .xor_in(xor_in), .cfg_comb(cfg_comb), .cfg_dsel(cfg_dsel),
    .cfg_fb_reg(cfg_fb_reg), .cfg_oe_sel(cfg_oe_sel), .oe_n(oe_n),
    .pt_oe(pt_oe), .pin_data(pin_data), .fb_out(fb_out), .pin_oe(pin_oe)
  );

  // R11
  reg_fb_match_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
    !cfg_comb |-> (fb_out == pin_data));
endmodule

// File: tb/mcell_reg_stage_test.sv
module mcell_reg_stage_test;
  logic rst_n, glb_clk, glb_clr_n;
  logic [1:0] oe_n;
  logic [2:0] cfg_mode, cfg_oe_sel;
  logic cfg_dsel, cfg_ptclk, cfg_ce_en, cfg_ap_en, cfg_comb, cfg_fb_reg;
  logic [1:0] cfg_ar_sel;
  logic xor_in, pt_data, pt_k, pt_clk, pt_ce, pt_ar, pt_ap, pt_oe;
  logic pin_data, pin_oe, fb_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  mcell_reg_stage uut (.*);

  initial glb_clk = 1'b0;
  always #5 glb_clk = ~glb_clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge glb_clk);
    #2;
  endtask

  task automatic at_low();
    @(negedge glb_clk);
    #1;
  endtask

  // Stores a known value through D mode from the XOR input
  task automatic load(input logic v);
    cfg_mode = 3'd0; cfg_dsel = 1'b0; xor_in = v;
    tick();
  endtask

  function automatic logic exp_next(input int m, input logic q, input logic a, input logic b);
    if (m == 1) return q ^ a;
    if (m == 2) return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
    if (m == 3) return b ? 1'b0 : (a ? 1'b1 : q);
    return a;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; glb_clr_n = 1; oe_n = 2'b11;
    cfg_mode = 0; cfg_dsel = 0; cfg_ptclk = 0; cfg_ce_en = 0; cfg_ar_sel = 0;
    cfg_ap_en = 0; cfg_comb = 0; cfg_fb_reg = 0; cfg_oe_sel = 0;
    xor_in = 1; pt_data = 1; pt_k = 0; pt_clk = 0; pt_ce = 0; pt_ar = 0;
    pt_ap = 0; pt_oe = 0;
    tick(); tick();
    // R1 reset holds the bit even with data 1 and clocks running
    chk("R1 pin", pin_data, 1'b0);
    chk("R1 fb", fb_out, 1'b0);
    at_low(); rst_n = 1;
    @(posedge glb_clk); #2;
    chk("R1 sync release", pin_data, 1'b0);
    tick(); tick();

    // R2 D mode over both sources and every data pattern, including codes 5..7
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 2 || m == 3 || m == 4) continue;
      for (int p = 0; p < 8; p++) begin
        cfg_mode = 3'(m); cfg_dsel = p[2]; xor_in = p[1]; pt_data = p[0];
        tick();
        chk("R2 D", pin_data, p[2] ? p[0] : p[1]);
      end
    end

    // R3, R4, R5 all starting states and input pairs
    for (int m = 1; m < 4; m++) begin
      for (int qs = 0; qs < 2; qs++) begin
        for (int ab = 0; ab < 4; ab++) begin
          load(qs[0]);
          cfg_mode = 3'(m); xor_in = ab[1]; pt_k = ab[0];
          tick();
          if (m == 1) chk("R3 T", pin_data, exp_next(m, qs[0], ab[1], ab[0]));
          if (m == 2) chk("R4 JK", pin_data, exp_next(m, qs[0], ab[1], ab[0]));
          if (m == 3) chk("R5 SR", pin_data, exp_next(m, qs[0], ab[1], ab[0]));
        end
      end
    end
    pt_k = 0;

    // R7 product-term clock: global edges ignored, pt_clk edge stores
    load(1'b0);
    at_low(); cfg_ptclk = 1; xor_in = 1;
    tick(); tick();
    chk("R7 glb ignored", pin_data, 1'b0);
    at_low(); pt_clk = 1; #1;
    chk("R7 pt edge", pin_data, 1'b1);
    // R8 enable has no effect on the product-term clock
    pt_clk = 0; cfg_ce_en = 1; pt_ce = 0; xor_in = 0;
    at_low(); pt_clk = 1; #1;
    chk("R8 ce unused on pt clk", pin_data, 1'b0);
    pt_clk = 0;

    // R6 latch on the product-term clock
    cfg_mode = 3'd4; cfg_ce_en = 0;
    at_low(); pt_clk = 1; xor_in = 1; #1;
    chk("R6 transparent 1", pin_data, 1'b1);
    xor_in = 0; #1;
    chk("R6 transparent 0", pin_data, 1'b0);
    xor_in = 1; #1; pt_clk = 0; #1;
    chk("R6 held at fall", pin_data, 1'b1);
    xor_in = 0; tick();
    chk("R6 holds while low", pin_data, 1'b1);
    at_low(); pt_clk = 1; #1;
    chk("R6 reopens", pin_data, 1'b0);
    pt_clk = 0; #1;
    at_low(); cfg_ptclk = 0;

    // R8 clock enable on the global clock
    load(1'b1);
    cfg_ce_en = 1; pt_ce = 0; xor_in = 0;
    tick(); tick();
    chk("R8 ce low ignores", pin_data, 1'b1);
    pt_ce = 1; tick();
    chk("R8 ce high stores", pin_data, 1'b0);
    cfg_ce_en = 0; pt_ce = 0;

    // R9 every reset source with every input combination
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        glb_clr_n = 1; pt_ar = 0; cfg_ar_sel = 0;
        load(1'b1);
        cfg_ar_sel = 2'(s); glb_clr_n = c[1]; pt_ar = c[0]; #1;
        chk("R9 async reset", pin_data,
            (((s & 1) != 0 && !c[1]) || ((s & 2) != 0 && c[0])) ? 1'b0 : 1'b1);
      end
    end
    glb_clr_n = 1; pt_ar = 0; cfg_ar_sel = 0;

    // R10 preset, then priority of reset over preset
    for (int p = 0; p < 4; p++) begin
      pt_ap = 0; cfg_ap_en = 0;
      load(1'b0);
      cfg_ap_en = p[1]; pt_ap = p[0]; #1;
      chk("R10 preset", pin_data, p[1] & p[0]);
    end
    pt_ap = 0; load(1'b0); load(1'b1);
    cfg_ap_en = 1; cfg_ar_sel = 2'd2; pt_ar = 1; pt_ap = 1; #1;
    chk("R10 reset wins", pin_data, 1'b0);
    pt_ap = 0; pt_ar = 0; cfg_ap_en = 0; cfg_ar_sel = 0;

    // R11 output and feedback selection
    for (int k = 0; k < 8; k++) begin
      cfg_comb = 0; cfg_mode = 0; cfg_dsel = 1; pt_data = 1;
      tick();
      cfg_comb = k[2]; cfg_dsel = k[1]; cfg_fb_reg = k[0]; xor_in = 0; pt_data = 1; #1;
      // stored bit is 1 in every case here, xor_in is 0
      chk("R11 pin", pin_data, k[2] ? 1'b0 : 1'b1);
      chk("R11 fb", fb_out, (!k[2] || (k[1] && k[0])) ? 1'b1 : 1'b0);
    end
    cfg_comb = 0; cfg_fb_reg = 0; cfg_dsel = 0;

    // R12 output-enable sweep
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic e;
        cfg_oe_sel = 3'(s); oe_n = c[2:1]; pt_oe = c[0]; #1;
        case (s)
          0: e = 1'b1;
          2: e = ~c[1];
          3: e = ~c[2];
          4: e = c[0];
          default: e = 1'b0;
        endcase
        chk("R12 oe", pin_oe, e);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule